// File: doc/BRIEF.md
# Shared Prescaler Tick Generator

This block derives count-enable pulses for a five-channel timer from one fixed reference clock. Two 8-bit prescale values live in a first configuration word and five 4-bit divider selects live in a second word. Each channel's enable is the reference clock divided first by its group's prescale stage and then by a power-of-two post-divider of its own. The first two channels share one prescale stage and the last three share the other.

Both words are presented on input buses and captured together by a single write strobe. That strobe also restarts every prescale and post-divider counter from zero, so the new rate takes effect from a known phase. The outputs are five single-cycle enables that the timer counters use as their count strobes.

Top module: `prescale_tick_gen`

## Requirements
- R1: After reset the first word holds 0x0101 and the second holds 0, so every channel ticks with a period of 2 cycles. All ticks are low while reset is asserted, and the first tick comes in the second cycle after reset is released.
- R2: Channel n ticks once every N = (P + 1) * 2^D reference cycles. P is the prescale value of its group and D is its divider select.
- R3: Channels 0 and 1 take P from bits [7:0] of the first word. Channels 2, 3 and 4 take P from bits [15:8]. A tick is raised only in a cycle where its group's prescale stage pulses.
- R4: Channel n takes D from bits [4n+3:4n] of the second word.
- R5: A cycle with cfg_wr high loads both words and restarts all counters. The first tick at the new rate is asserted in cycle N-1 after that clock edge, where cycle 0 is the one right after the edge. No tick comes in cycle 0 unless N is 1.
- R6: Changes on the word inputs while cfg_wr is low have no effect on any tick.
- R7: A tick is one reference cycle wide and never comes in two consecutive cycles unless its N is 1. When N is 1 the tick is high every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Capture both words and restart all counters |
| pre_word_in | input | 32 | Prescale word: group 0 in [7:0], group 1 in [15:8] |
| div_word_in | input | 32 | Divider select word: channel n in [4n+3:4n] |
| tick | output | 5 | Per-channel one-cycle count enables |

## Verification
A corrupted prescale or post-divider count shows at the ports as a tick that comes early or late. After a restart that error appears within one channel period, and it repeats every period afterwards. A wrong field mapping gives the wrong period on a whole group, or on a single channel, from the first tick after the strobe. A restart that is lost or ignored shifts the phase, so the first expected tick in the scoreboard window is missed. Spurious back-to-back pulses are visible in the cycle right after the first one.

// File: rtl/tickgen_pkg.sv
package tickgen_pkg;
  localparam int PRE_W  = 8;
  localparam int SEL_W  = 4;
  localparam int WORD_W = 32;

  // group index of a channel: channels below split use group 0
  function automatic int unsigned group_of(input int unsigned ch, input int unsigned split);
    return (ch < split) ? 0 : 1;
  endfunction

  // terminal count of a post-divider for a given select
  function automatic logic [(1<<SEL_W)-2:0] term_mask(input logic [SEL_W-1:0] sel);
    logic [(1<<SEL_W)-2:0] m;
    m = '0;
    for (int b = 0; b < (1<<SEL_W)-1; b++) begin
      if (b < int'(sel)) m[b] = 1'b1;
    end
    return m;
  endfunction

  // total division ratio of a channel
  function automatic logic [31:0] total_div(input logic [PRE_W-1:0] pre, input logic [SEL_W-1:0] sel);
    return (32'(pre) + 32'd1) << sel;
  endfunction

  // reset value of the prescale word: each group field set to 1
  function automatic logic [WORD_W-1:0] pre_reset(input int unsigned groups);
    logic [WORD_W-1:0] v;
    v = '0;
    for (int g = 0; g < 2; g++) begin
      if (g < int'(groups)) v[g*PRE_W] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/prescale_stage.sv
module prescale_stage #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic             stage
);
  logic [PRE_W-1:0] cnt_q;

  assign stage = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
    end else if (stage) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/post_divider.sv
module post_divider
  import tickgen_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          stage,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  localparam int CNT_W = (1 << SW) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  assign mask = CNT_W'(term_mask(SEL_W'(sel)));
  assign tick = stage && (cnt_q == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
    end else if (stage) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/prescale_tick_gen.sv
module prescale_tick_gen
  import tickgen_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int SPLIT  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [WORD_W-1:0]     pre_word_in,
  input  logic [WORD_W-1:0]     div_word_in,
  output logic [NUM_CH-1:0]     tick
);
  localparam int NUM_GRP = 2;
  localparam logic [WORD_W-1:0] PRE_RST = pre_reset(NUM_GRP);

  logic [WORD_W-1:0]  pre_q;
  logic [WORD_W-1:0]  div_q;
  logic               restart;
  logic [NUM_GRP-1:0] stage_pulse;

  assign restart = cfg_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= PRE_RST;
      div_q <= '0;
    end else if (cfg_wr) begin
      pre_q <= pre_word_in;
      div_q <= div_word_in;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
    prescale_stage #(.PRE_W(PRE_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .limit   (pre_q[g*PRE_W +: PRE_W]),
      .stage   (stage_pulse[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = group_of(c, SPLIT);
    post_divider #(.SW(SEL_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .stage   (stage_pulse[GRP]),
      .sel     (div_q[c*SEL_W +: SEL_W]),
      .tick    (tick[c])
    );
  end
endmodule

// File: rtl/tick_gen_checks.sv
module tick_gen_checks
  import tickgen_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int SPLIT  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [NUM_CH-1:0] tick,
  input logic [1:0]        stage_pulse,
  input logic [WORD_W-1:0] pre_q,
  input logic [WORD_W-1:0] div_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam int GRP = group_of(c, SPLIT);
    logic [31:0] ratio;
    logic [31:0] elapsed;

    assign ratio = total_div(pre_q[GRP*PRE_W +: PRE_W], div_q[c*SEL_W +: SEL_W]);

    always_ff @(posedge clk) begin
      if (!rst_n || cfg_wr || tick[c]) elapsed <= '0;
      else elapsed <= elapsed + 32'd1;
    end

    // R2: a tick lands exactly one period after the last tick or restart
    assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |-> (elapsed == ratio - 32'd1));

    // R2: no tick is skipped
    assert_no_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
      elapsed < ratio);

    // R3: a tick only comes with its group's stage pulse
    assert_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |-> stage_pulse[GRP]);

    // R5: no tick right after a restart unless the period is one
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (!tick[c] || ratio == 32'd1));

    // R7: no back-to-back ticks unless the period is one
    assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[c] && !cfg_wr && ratio != 32'd1) |=> !tick[c]);
  end
endmodule

bind prescale_tick_gen tick_gen_checks #(.NUM_CH(NUM_CH), .SPLIT(SPLIT)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .tick        (tick),
  .stage_pulse (stage_pulse),
  .pre_q       (pre_q),
  .div_q       (div_q)
);

// File: tb/test_prescale_tick_gen.sv
module test_prescale_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] pre_in = '0;
  logic [31:0] div_in = '0;
  logic [4:0]  tick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [4:0] exp;
    int         cyc;
    string      tag;
  } item_t;

  item_t q[$];

  always #4 clk = ~clk;

  prescale_tick_gen i_prescale_tick_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .pre_word_in (pre_in),
    .div_word_in (div_in),
    .tick        (tick)
  );

  // expected period of channel ch, restated from R2/R3/R4
  function automatic int period(input logic [31:0] pw, input logic [31:0] dw, input int ch);
    int p;
    int d;
    p = (ch < 2) ? int'(pw[7:0]) : int'(pw[15:8]);
    d = int'(dw[ch*4 +: 4]);
    return (p + 1) * (1 << d);
  endfunction

  task automatic push_window(input logic [31:0] pw, input logic [31:0] dw,
                             input int len, input string tag);
    for (int k = 0; k < len; k++) begin
      item_t it;
      for (int ch = 0; ch < 5; ch++) begin
        it.exp[ch] = (((k + 1) % period(pw, dw, ch)) == 0);
      end
      it.cyc = k;
      it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic apply(input logic [31:0] pw, input logic [31:0] dw,
                       input bit scramble, input int len, input string tag);
    @(negedge clk);
    pre_in = pw;
    div_in = dw;
    cfg_wr = 1'b1;
    @(posedge clk);
    #1;
    cfg_wr = 1'b0;
    if (scramble) begin
      pre_in = 32'h0000_00F7;
      div_in = 32'h0009_A5C3;
    end
    push_window(pw, dw, len, tag);
    wait (q.size() == 0);
  endtask

  // monitor: compare one expected vector per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (tick !== it.exp) begin
        errors++;
        $display("FAIL %s cycle %0d: tick=%b expected=%b", it.tag, it.cyc, tick, it.exp);
      end
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (tick !== 5'b0) begin
        errors++;
        $display("FAIL R1 in reset: tick=%b expected=%b", tick, 5'b0);
      end
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    push_window(32'h0101, 32'h0, 12, "R1 reset rate");
    wait (q.size() == 0);

    apply(32'h0000_0302, 32'h0, 1'b0, 30, "R3 group prescale");
    apply(32'h0000_0000, 32'h0000_1230, 1'b0, 40, "R4 R7 divider fields");
    apply(32'h0000_0501, 32'h0004_3210, 1'b0, 200, "R2 mixed ratios");
    apply(32'h0000_0100, 32'h0001_1111, 1'b1, 40, "R5 R6 restart ignore");
    apply(32'h0000_0203, 32'h0000_0000, 1'b0, 25, "R5 restart phase");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule